// File: doc/BRIEF.md
# Audio codec master clock generator

This block takes the master clock of an audio codec and derives every timing signal the digital core needs. It runs entirely in the master clock domain. It does not produce gated clocks. It produces strobes and levels that are registered or decoded from registers:
- a core clock enable, which marks each cycle where the internal core clock ticks;
- a clock-output tick, which marks each rising edge of the buffered clock output;
- in master mode, a bit clock level and a left/right frame clock level.

The core clock runs at either the full master rate or half of it. The clock output follows either the core clock or half of it, and a power-down input silences it. In master mode, two inputs pick the number of core clocks per sample. One selects the clock family (audio or 12 MHz USB) and the other selects the base rate. A frame counter splits each sample period into a left half and a right half. A bit-period counter, restarted at the start of every half, produces the bit clock.

A ratio change on the inputs waits for the end of the current sample period before it is used. Dropping the master enable parks both serial clocks low and clears the counters. Raising it again starts a fresh frame.

Top module: `codec_clkgen`

## Requirements
- R1: With `core_half` = 0, `core_en` is 1 in every master clock cycle.
- R2: With `core_half` = 1, `core_en` is 1 in every second master clock cycle: 20 of any 40 consecutive cycles.
- R3: With `cko_half` = 0 and `cko_off` = 0, `cko_tick` is 1 in every cycle where `core_en` is 1.
- R4: With `cko_half` = 1 and `cko_off` = 0, `cko_tick` marks every second core tick. Over 40 cycles this gives 20 ticks at full core rate and 10 ticks at half core rate.
- R5: With `cko_off` = 1, `cko_tick` stays 0, while `core_en` keeps running.
- R6: With `usb_mode` = 0, one sample period (from one falling edge of `fclk` to the next) lasts 256 core ticks when `rate_alt` = 0 and 384 core ticks when `rate_alt` = 1.
- R7: With `usb_mode` = 1, one sample period lasts 250 core ticks when `rate_alt` = 0 and 272 core ticks when `rate_alt` = 1.
- R8: `fclk` is 0 for the first half of each sample period and 1 for the second half, and each half lasts exactly half the ratio in core ticks. Frame clock edges occur only on core ticks.
- R9: In audio-family ratios, each half holds 32 bit periods with equal high and low parts: 2+2 core ticks at 256, 3+3 at 384. In USB-family ratios, a bit period is 1 core tick high and 1 low. Every half starts with `bclk` high.
- R10: When a half has an odd number of core ticks (the 250 ratio), the leftover final tick of the half is added to the bit clock low phase. The result is 124 bit periods per sample and a longest low run of 2 ticks.
- R11: A change of `usb_mode` or `rate_alt` during a sample period does not alter that period. It applies from the next period, which starts at a falling edge of `fclk`.
- R12: While `master_en` is 0, `bclk` and `fclk` are 0. One cycle after `master_en` rises, a new frame begins with `fclk` = 0 and `bclk` = 1. `fclk` first rises half a ratio plus one cycle after the enable.
- R13: Synchronous active-low reset clears all dividers. During reset `bclk` and `fclk` are 0. After release, the frame restarts from zero with the same timing as in R12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_half | input | 1 | 1: core clock is master clock divided by 2 |
| cko_half | input | 1 | 1: clock output is core clock divided by 2 |
| cko_off | input | 1 | 1: clock output powered down |
| master_en | input | 1 | 1: generate bit and frame clocks |
| usb_mode | input | 1 | 0: audio-family ratios, 1: USB-family ratios |
| rate_alt | input | 1 | Base-rate select within the family (256/384 or 250/272) |
| core_en | output | 1 | Core clock tick strobe |
| cko_tick | output | 1 | Rising-edge strobe of the clock output |
| bclk | output | 1 | Bit clock level |
| fclk | output | 1 | Frame clock level: 0 = left half, 1 = right half |

## Verification
The hardest case to reach is a ratio change that arrives partway through a sample period. It has to land after the period has started and well before it ends, and the effect can only be seen by timing two whole periods in a row. The bench first aligns to a falling edge of `fclk`. It changes the base-rate input ten cycles later, then times the period in progress and the one that follows. The odd-half stretch of the 250 ratio gets similar treatment: the bench measures every high and low run of `bclk` over a full frame, so a misplaced extra tick shows up as a wrong run length or a wrong edge count.

// File: rtl/codec_clkgen_pkg.sv
// Shared types and helpers for the codec clock generator.
// Assumes: ratio selection is formed as {usb_mode, rate_alt}.
package codec_clkgen_pkg;

    // Ratio selection, indexed by {family, base-rate}
    typedef enum logic [1:0] {
        RATE_NORM_LO = 2'b00,
        RATE_NORM_HI = 2'b01,
        RATE_USB_LO  = 2'b10,
        RATE_USB_HI  = 2'b11
    } rate_e;

    // Largest of four elaboration-time values
    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/codec_clkgen_core.sv
// Core clock enable and clock-output tick generation.
// Produces a strobe for each core clock tick (master or master/2) and a
// strobe for each rising edge of the clock output (core or core/2).
// Assumes: all outputs are used as enables in the master clock domain.
module codec_clkgen_core (
    input  logic clk,
    input  logic rst_n,
    input  logic core_half,
    input  logic cko_half,
    input  logic cko_off,
    output logic core_en,
    output logic cko_tick
);

    logic core_tgl_q;
    logic cko_tgl_q;

    // Toggle that halves the master clock when core_half is set
    always_ff @(posedge clk) begin
        if (!rst_n)
            core_tgl_q <= 1'b0;
        else if (core_half)
            core_tgl_q <= ~core_tgl_q;
        else
            core_tgl_q <= 1'b0;
    end

    assign core_en = !core_half || core_tgl_q;

    // Toggle that halves the core tick rate for the clock output
    always_ff @(posedge clk) begin
        if (!rst_n)
            cko_tgl_q <= 1'b0;
        else if (!cko_half)
            cko_tgl_q <= 1'b0;
        else if (core_en)
            cko_tgl_q <= ~cko_tgl_q;
    end

    assign cko_tick = !cko_off && core_en && (!cko_half || cko_tgl_q);

    // R2
    core_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && core_half && $past(core_half) |-> core_en != $past(core_en));

    // R4
    cko_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cko_half && cko_tick |=> !cko_tick || !cko_half);

    // R5
    cko_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cko_off && $past(cko_off) && $past(rst_n) |-> !cko_tick && !$past(cko_tick));

endmodule

// File: rtl/codec_clkgen_frame.sv
// Master-mode bit and frame clock generator.
// Counts core ticks within each frame half, toggles the frame clock at the
// end of each half, and splits each half into bit periods. A leftover tick
// in an odd-length half extends the last bit clock low phase.
// Assumes: each audio-family half divides evenly into NORM_BITS_HALF
// periods of even length, and USB_BIT_DIV is even.
module codec_clkgen_frame
    import codec_clkgen_pkg::*;
#(
    parameter int NORM_LO        = 256,
    parameter int NORM_HI        = 384,
    parameter int USB_LO         = 250,
    parameter int USB_HI         = 272,
    parameter int NORM_BITS_HALF = 32,
    parameter int USB_BIT_DIV    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic core_en,
    input  logic master_en,
    input  logic usb_mode,
    input  logic rate_alt,
    output logic bclk,
    output logic fclk
);

    localparam int HALF_NL  = NORM_LO / 2;
    localparam int HALF_NH  = NORM_HI / 2;
    localparam int HALF_UL  = USB_LO / 2 + USB_LO % 2;
    localparam int HALF_UH  = USB_HI / 2 + USB_HI % 2;
    localparam int BDIV_NL  = HALF_NL / NORM_BITS_HALF;
    localparam int BDIV_NH  = HALF_NH / NORM_BITS_HALF;
    localparam int MAX_HALF = max4(HALF_NL, HALF_NH, HALF_UL, HALF_UH);
    localparam int MAX_BDIV = max4(BDIV_NL, BDIV_NH, USB_BIT_DIV, USB_BIT_DIV);
    localparam int CNT_W    = $clog2(MAX_HALF + 1);
    localparam int PH_W     = $clog2(MAX_BDIV + 1);

    rate_e            cfg_q;
    logic             run_q;
    logic             side_q;
    logic [CNT_W-1:0] pos_q;
    logic [PH_W-1:0]  ph_q;
    logic [CNT_W-1:0] half_len;
    logic [PH_W-1:0]  bdiv;
    logic             half_end;
    logic             frame_end;

    // Half length and bit period for the ratio latched for this frame
    always_comb begin
        case (cfg_q)
            RATE_NORM_LO: begin half_len = CNT_W'(HALF_NL); bdiv = PH_W'(BDIV_NL);     end
            RATE_NORM_HI: begin half_len = CNT_W'(HALF_NH); bdiv = PH_W'(BDIV_NH);     end
            RATE_USB_LO:  begin half_len = CNT_W'(HALF_UL); bdiv = PH_W'(USB_BIT_DIV); end
            default:      begin half_len = CNT_W'(HALF_UH); bdiv = PH_W'(USB_BIT_DIV); end
        endcase
    end

    assign half_end  = (pos_q == half_len - CNT_W'(1));
    assign frame_end = run_q && core_en && side_q && half_end;

    // Run flag: registered master enable, restarts the frame on rise
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else
            run_q <= master_en;
    end

    // Ratio latch: follows the inputs while idle, else reloads at frame end
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= RATE_NORM_LO;
        else if (!run_q || frame_end)
            cfg_q <= rate_e'({usb_mode, rate_alt});
    end

    // Half-position counter and frame side
    always_ff @(posedge clk) begin
        if (!rst_n || !run_q) begin
            pos_q  <= '0;
            side_q <= 1'b0;
        end else if (core_en) begin
            if (half_end) begin
                pos_q  <= '0;
                side_q <= ~side_q;
            end else begin
                pos_q  <= pos_q + CNT_W'(1);
            end
        end
    end

    // Bit-period phase counter, restarted at every half
    always_ff @(posedge clk) begin
        if (!rst_n || !run_q)
            ph_q <= '0;
        else if (core_en) begin
            if (half_end || ph_q == bdiv - PH_W'(1))
                ph_q <= '0;
            else
                ph_q <= ph_q + PH_W'(1);
        end
    end

    assign bclk = run_q && (ph_q < (bdiv >> 1)) && !(half_len[0] && half_end);
    assign fclk = run_q && side_q;

    // R6
    pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q < half_len);

    // R8
    fclk_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(run_q) && !$past(core_en) |-> side_q == $past(side_q));

    // R9
    half_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && run_q && $past(run_q) && side_q != $past(side_q) |-> bclk);

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && run_q && $past(run_q) && !$past(frame_end) |-> cfg_q == $past(cfg_q));

endmodule

// File: rtl/codec_clkgen.sv
// Top of the codec clock generator: core/clock-output dividers plus the
// master-mode bit and frame clock generator.
// Assumes: a single master clock domain; outputs are strobes and levels.
module codec_clkgen #(
    parameter int NORM_LO        = 256,
    parameter int NORM_HI        = 384,
    parameter int USB_LO         = 250,
    parameter int USB_HI         = 272,
    parameter int NORM_BITS_HALF = 32,
    parameter int USB_BIT_DIV    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic core_half,
    input  logic cko_half,
    input  logic cko_off,
    input  logic master_en,
    input  logic usb_mode,
    input  logic rate_alt,
    output logic core_en,
    output logic cko_tick,
    output logic bclk,
    output logic fclk
);

    logic core_tick;

    codec_clkgen_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .core_half (core_half),
        .cko_half  (cko_half),
        .cko_off   (cko_off),
        .core_en   (core_tick),
        .cko_tick  (cko_tick)
    );

    codec_clkgen_frame #(
        .NORM_LO        (NORM_LO),
        .NORM_HI        (NORM_HI),
        .USB_LO         (USB_LO),
        .USB_HI         (USB_HI),
        .NORM_BITS_HALF (NORM_BITS_HALF),
        .USB_BIT_DIV    (USB_BIT_DIV)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .core_en   (core_tick),
        .master_en (master_en),
        .usb_mode  (usb_mode),
        .rate_alt  (rate_alt),
        .bclk      (bclk),
        .fclk      (fclk)
    );

    assign core_en = core_tick;

    // R12
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(master_en) |-> !bclk && !fclk);

endmodule

// File: tb/codec_clkgen_test.sv
`timescale 1ns/1ps
module codec_clkgen_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_half = 1'b0, cko_half = 1'b0, cko_off = 1'b0;
    logic master_en = 1'b0, usb_mode = 1'b0, rate_alt = 1'b0;
    logic core_en, cko_tick, bclk, fclk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    codec_clkgen uut (
        .clk(clk), .rst_n(rst_n), .core_half(core_half), .cko_half(cko_half),
        .cko_off(cko_off), .master_en(master_en), .usb_mode(usb_mode),
        .rate_alt(rate_alt), .core_en(core_en), .cko_tick(cko_tick),
        .bclk(bclk), .fclk(fclk)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_ticks(input int n, output int ce, output int ck);
        ce = 0; ck = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ce += int'(core_en);
            ck += int'(cko_tick);
        end
    endtask

    // Restart master mode with a given divider and ratio setup
    task automatic restart(input logic ch, input logic usb, input logic alt);
        @(negedge clk);
        master_en = 1'b0;
        wait_cycles(3);
        core_half = ch; usb_mode = usb; rate_alt = alt;
        master_en = 1'b1;
    endtask

    task automatic sync_fall();
        logic prev;
        prev = fclk;
        forever begin
            @(negedge clk);
            if (prev && !fclk) break;
            prev = fclk;
        end
    endtask

    // Measure one frame starting at a falling edge of fclk just observed
    task automatic frame_from_here(output int len, output int hi, output int rises,
                                   output int maxh, output int maxl);
        logic pf, pb;
        int runl;
        pf = fclk; pb = bclk; runl = 1;
        len = 0; hi = 0; rises = 0; maxh = 0; maxl = 0;
        forever begin
            @(negedge clk);
            len++;
            hi += int'(fclk);
            if (bclk && !pb) rises++;
            if (bclk == pb) runl++; else runl = 1;
            if (bclk && runl > maxh) maxh = runl;
            if (!bclk && runl > maxl) maxl = runl;
            pb = bclk;
            if (pf && !fclk) break;
            pf = fclk;
            if (len > 2000) break;
        end
    endtask

    task automatic test_reset_state();
        rst_n = 1'b0;
        wait_cycles(3);
        check("R13 bclk in reset", int'(bclk), 0);
        check("R13 fclk in reset", int'(fclk), 0);
        rst_n = 1'b1;
        wait_cycles(2);
    endtask

    task automatic test_dividers();
        int ce, ck;
        core_half = 0; cko_half = 0; cko_off = 0;
        wait_cycles(4);
        count_ticks(40, ce, ck);
        check("R1 core ticks full rate", ce, 40);
        check("R3 cko ticks at core rate", ck, 40);
        cko_half = 1; wait_cycles(4);
        count_ticks(40, ce, ck);
        check("R4 cko ticks halved", ck, 20);
        core_half = 1; wait_cycles(4);
        count_ticks(40, ce, ck);
        check("R2 core ticks halved", ce, 20);
        check("R4 cko ticks quartered", ck, 10);
        cko_off = 1; wait_cycles(4);
        count_ticks(40, ce, ck);
        check("R5 cko silent when off", ck, 0);
        check("R5 core keeps running", ce, 20);
        cko_off = 0; cko_half = 0; core_half = 0;
    endtask

    task automatic test_master_enable();
        int highs, n;
        @(negedge clk);
        master_en = 0; core_half = 0; usb_mode = 0; rate_alt = 0;
        highs = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            highs += int'(bclk) + int'(fclk);
        end
        check("R12 idle clocks low", highs, 0);
        master_en = 1;
        @(negedge clk);
        check("R12 first bclk high", int'(bclk), 1);
        check("R12 first fclk low", int'(fclk), 0);
        n = 1;
        while (!fclk && n < 1000) begin @(negedge clk); n++; end
        check("R12 R8 first fclk rise", n, 129);
    endtask

    task automatic test_ratio(input string tag, input logic ch, input logic usb,
                              input logic alt, input int exp_len, input int exp_hi,
                              input int exp_rises, input int exp_h, input int exp_l);
        int len, hi, rises, mh, ml;
        restart(ch, usb, alt);
        sync_fall();
        frame_from_here(len, hi, rises, mh, ml);
        check({tag, " frame length"}, len, exp_len);
        check({"R8 fclk high half ", tag}, hi, exp_hi);
        check({"R9 bclk periods ", tag}, rises, exp_rises);
        check({"R9 bclk high run ", tag}, mh, exp_h);
        check({"R9 R10 bclk low run ", tag}, ml, exp_l);
    endtask

    task automatic test_cfg_change();
        int cnt, len, hi, rises, mh, ml;
        logic pf;
        restart(1'b0, 1'b0, 1'b0);
        sync_fall();
        cnt = 0; pf = fclk;
        forever begin
            @(negedge clk);
            cnt++;
            if (cnt == 10) rate_alt = 1'b1;
            if (pf && !fclk) break;
            pf = fclk;
            if (cnt > 2000) break;
        end
        check("R11 current frame kept", cnt, 256);
        frame_from_here(len, hi, rises, mh, ml);
        check("R11 next frame uses new ratio", len, 384);
    endtask

    task automatic test_midrun_reset();
        int n;
        restart(1'b0, 1'b0, 1'b0);
        wait_cycles(300);
        rst_n = 1'b0;
        wait_cycles(3);
        check("R13 fclk cleared by reset", int'(fclk), 0);
        rst_n = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!fclk && n < 1000);
        check("R13 frame restarts from zero", n, 129);
    endtask

    initial begin
        test_reset_state();
        test_dividers();
        test_master_enable();
        test_ratio("R6 n256", 1'b0, 1'b0, 1'b0, 256, 128, 64, 2, 2);
        test_ratio("R6 n384", 1'b0, 1'b0, 1'b1, 384, 192, 64, 3, 3);
        test_ratio("R7 u250", 1'b0, 1'b1, 1'b0, 250, 125, 124, 1, 2);
        test_ratio("R7 u272", 1'b0, 1'b1, 1'b1, 272, 136, 136, 1, 1);
        test_ratio("R2 R6 n256 half core", 1'b1, 1'b0, 1'b0, 512, 256, 64, 4, 4);
        test_cfg_change();
        test_midrun_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule